// File: doc/BRIEF.md
# Banked Interrupt Status Controller

This block gathers up to 160 hardware event lines into five 32-bit banks. Only 137 of those lines are populated. Each bank holds one enable word and one pending word.

A rising edge on an event line latches the matching pending bit, whether or not that source is enabled. The pending bit stays set until software writes a 1 to it. A pending bit drives an output only while its enable bit is set.

Banks 0 to 2 form the functional group and drive `irq_fn`. Banks 3 and 4 form the error group and drive `irq_err`. Both outputs are level signals.

Software reaches the ten words through a plain register port. Writes are single-cycle and reads are combinational. Source numbers follow bit positions: source n lives in bank n/32 at bit n%32, on input `evt_in[n]`. The unpopulated gaps are kept, so the first source of bank 3 is number 96.

The block has no state machine. Its only state is the edge-detect register and, in each bank, the enable word and the pending word.

Top module: `evt_irq_ctrl`

## Requirements
- R1: A synchronous active-low reset clears every enable bit, every pending bit and the edge history, and holds `irq_fn` and `irq_err` low.
- R2: A 0-to-1 change on a populated `evt_in[n]` sets pending bit n at the first rising clock edge that samples it high, enabled or not. An input held high does not set the bit again after it has been cleared.
- R3: A write to a pending word clears exactly the bits written as 1. Bits written as 0 keep their value.
- R4: If an edge and a clearing write reach the same pending bit in the same cycle, the bit ends up set.
- R5: The populated widths of banks 0 to 4 are 32, 32, 24, 32 and 17 bits, using the low bits of each word. Unpopulated enable and pending bits always read 0, and edges on unpopulated inputs are ignored.
- R6: `irq_fn` is high exactly while some bit in banks 0 to 2 is both pending and enabled.
- R7: `irq_err` is high exactly while some bit in banks 3 and 4 is both pending and enabled.
- R8: The group outputs are level-sensitive. A group output stays high until every enabled pending bit of its group is cleared or masked, and setting the enable bit again re-asserts it.
- R9: All addresses are byte addresses, word aligned. The enable word of bank b is at 4*b (0x00 to 0x10) and the pending word at 0x14 + 4*b (0x14 to 0x24). Any other address reads 0, and a write to it changes nothing.
- R10: Source n maps to bank n/32, bit n%32; for example, source 96 is bit 0 of bank 3 and source 130 is bit 2 of bank 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_in | input | 160 | Event lines, index = source number |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_fn | output | 1 | Functional group interrupt level |
| irq_err | output | 1 | Error group interrupt level |

## Verification
The assertions assume that event lines are low while reset is held. Without that, the first edge after reset would be seen as a genuine event. They also assume that each write strobe lasts a single clock cycle. The stimulus changes inputs only on falling clock edges and keeps every event line low across each reset. An event is driven as a one-cycle pulse, except in the test of a held line. A read only moves the address and never raises `bus_wr`.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

    // Register word kinds seen by the address decoder.
    typedef enum logic [1:0] {
        REG_NONE   = 2'd0,
        REG_ENABLE = 2'd1,
        REG_STATUS = 2'd2
    } reg_kind_e;

    // Populated width of bank b from a list of 8-bit widths (bank 0 lowest).
    function automatic int unsigned pop_width(input logic [63:0] list, input int unsigned b);
        logic [7:0] w;
        w = list[b*8 +: 8];
        return int'(w);
    endfunction

    // Mask of the populated low bits of a 32-bit word.
    function automatic logic [31:0] pop_mask(input int unsigned width);
        logic [31:0] m;
        m = '0;
        for (int unsigned i = 0; i < 32; i++) begin
            if (i < width) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/evt_rise_detect.sv
module evt_rise_detect #(
    parameter int unsigned WIDTH = 160
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] evt_in,
    output logic [WIDTH-1:0] rise
);

    logic [WIDTH-1:0] evt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) evt_q <= '0;
        else        evt_q <= evt_in;
    end

    assign rise = rst_n ? (evt_in & ~evt_q) : '0;

endmodule

// File: rtl/evt_reg_decode.sv
module evt_reg_decode
    import evt_irq_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 5,
    parameter int unsigned ADDR_W    = 8,
    localparam int unsigned BIDX_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic [ADDR_W-1:0]   addr,
    output reg_kind_e           kind,
    output logic [BIDX_W-1:0]   bank
);

    localparam int unsigned WIDX_W = ADDR_W - 2;
    localparam logic [WIDX_W-1:0] NB  = WIDX_W'(NUM_BANKS);
    localparam logic [WIDX_W-1:0] NB2 = WIDX_W'(2 * NUM_BANKS);

    logic [WIDX_W-1:0] word;
    logic [WIDX_W-1:0] off;

    assign word = addr[ADDR_W-1:2];

    always_comb begin
        kind = REG_NONE;
        off  = '0;
        if (addr[1:0] == 2'b00) begin
            if (word < NB) begin
                kind = REG_ENABLE;
                off  = word;
            end else if (word < NB2) begin
                kind = REG_STATUS;
                off  = word - NB;
            end
        end
        bank = off[BIDX_W-1:0];
    end

endmodule

// File: rtl/evt_bank_regs.sv
module evt_bank_regs #(
    parameter int unsigned WORD_W   = 32,
    parameter logic [WORD_W-1:0] POP_MASK = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_we,
    input  logic              st_we,
    input  logic [WORD_W-1:0] wdata,
    input  logic [WORD_W-1:0] rise,
    output logic [WORD_W-1:0] en_q,
    output logic [WORD_W-1:0] st_q
);

    logic [WORD_W-1:0] en_d;
    logic [WORD_W-1:0] clr;
    logic [WORD_W-1:0] st_d;

    always_comb begin
        en_d = en_we ? (wdata & POP_MASK) : en_q;
        clr  = st_we ? wdata : '0;
        // A new edge outranks a clearing write on the same bit.
        st_d = ((st_q & ~clr) | rise) & POP_MASK;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
            st_q <= '0;
        end else begin
            en_q <= en_d;
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
    import evt_irq_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 5,
    parameter int unsigned FN_BANKS  = 3,
    parameter int unsigned WORD_W    = 32,
    parameter int unsigned ADDR_W    = 8,
    parameter logic [63:0] POP_LIST  = {24'd0, 8'd17, 8'd32, 8'd24, 8'd32, 8'd32},
    localparam int unsigned NSRC     = NUM_BANKS * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   evt_in,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              irq_fn,
    output logic              irq_err
);

    localparam int unsigned BIDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

    logic [NSRC-1:0]               rise;
    logic [NUM_BANKS-1:0][WORD_W-1:0] en_q;
    logic [NUM_BANKS-1:0][WORD_W-1:0] st_q;
    logic [NUM_BANKS-1:0]          bank_pend;
    reg_kind_e                     kind;
    logic [BIDX_W-1:0]             bank_sel;

    evt_rise_detect #(.WIDTH(NSRC)) u_rise (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_in (evt_in),
        .rise   (rise)
    );

    evt_reg_decode #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .kind (kind),
        .bank (bank_sel)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam logic [WORD_W-1:0] MASK = WORD_W'(pop_mask(pop_width(POP_LIST, b)));
        logic en_we;
        logic st_we;

        assign en_we = bus_wr && (kind == REG_ENABLE) && (bank_sel == BIDX_W'(b));
        assign st_we = bus_wr && (kind == REG_STATUS) && (bank_sel == BIDX_W'(b));

        evt_bank_regs #(.WORD_W(WORD_W), .POP_MASK(MASK)) u_regs (
            .clk   (clk),
            .rst_n (rst_n),
            .en_we (en_we),
            .st_we (st_we),
            .wdata (bus_wdata),
            .rise  (rise[b*WORD_W +: WORD_W]),
            .en_q  (en_q[b]),
            .st_q  (st_q[b])
        );

        assign bank_pend[b] = |(en_q[b] & st_q[b]);
    end

    // Group aggregation: banks below FN_BANKS form the functional group.
    always_comb begin
        irq_fn  = 1'b0;
        irq_err = 1'b0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (b < FN_BANKS) irq_fn  = irq_fn  | bank_pend[b];
            else              irq_err = irq_err | bank_pend[b];
        end
    end

    always_comb begin
        unique case (kind)
            REG_ENABLE: bus_rdata = en_q[bank_sel];
            REG_STATUS: bus_rdata = st_q[bank_sel];
            default:    bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/evt_irq_checker.sv
module evt_irq_checker
    import evt_irq_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 5,
    parameter int unsigned FN_BANKS  = 3,
    parameter int unsigned WORD_W    = 32,
    parameter int unsigned ADDR_W    = 8,
    parameter logic [63:0] POP_LIST  = {24'd0, 8'd17, 8'd32, 8'd24, 8'd32, 8'd32}
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic [NUM_BANKS*WORD_W-1:0]      evt_in,
    input logic                             bus_wr,
    input logic [ADDR_W-1:0]                bus_addr,
    input logic [WORD_W-1:0]                bus_wdata,
    input logic                             irq_fn,
    input logic                             irq_err,
    input logic [NUM_BANKS-1:0][WORD_W-1:0] en_q,
    input logic [NUM_BANKS-1:0][WORD_W-1:0] st_q
);

    logic [NUM_BANKS*WORD_W-1:0] evt_prev;
    logic fn_want;
    logic err_want;

    always_ff @(posedge clk) begin
        if (!rst_n) evt_prev <= '0;
        else        evt_prev <= evt_in;
    end

    always_comb begin
        fn_want  = 1'b0;
        err_want = 1'b0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (b < FN_BANKS) fn_want  = fn_want  | (|(st_q[b] & en_q[b]));
            else              err_want = err_want | (|(st_q[b] & en_q[b]));
        end
    end

    assert_fn_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_fn == fn_want);

    assert_err_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_err == err_want);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
        localparam logic [WORD_W-1:0] MASK = WORD_W'(pop_mask(pop_width(POP_LIST, b)));
        localparam logic [ADDR_W-1:0] ST_ADDR = ADDR_W'(4 * (NUM_BANKS + b));
        logic st_wr;
        assign st_wr = bus_wr && (bus_addr == ST_ADDR);

        assert_unpop_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
            ((st_q[b] | en_q[b]) & ~MASK) == '0);

        for (genvar i = 0; i < WORD_W; i++) begin : g_bit
            if (MASK[i]) begin : g_pop
                // R2 and R4: an edge always leaves the bit set, even under a clear.
                assert_rise_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
                    (evt_in[b*WORD_W+i] && !evt_prev[b*WORD_W+i]) |=> st_q[b][i]);

                assert_hold_unless_cleared_R3: assert property (@(posedge clk) disable iff (!rst_n)
                    (st_q[b][i] && !(st_wr && bus_wdata[i])) |=> st_q[b][i]);
            end
        end
    end

endmodule

bind evt_irq_ctrl evt_irq_checker #(
    .NUM_BANKS (NUM_BANKS),
    .FN_BANKS  (FN_BANKS),
    .WORD_W    (WORD_W),
    .ADDR_W    (ADDR_W),
    .POP_LIST  (POP_LIST)
) u_evt_irq_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_in    (evt_in),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq_fn    (irq_fn),
    .irq_err   (irq_err),
    .en_q      (en_q),
    .st_q      (st_q)
);

// File: tb/evt_irq_ctrl_bench.sv
module evt_irq_ctrl_bench;

    localparam int NSRC = 160;

    typedef enum logic [1:0] { OP_WR = 2'd0, OP_RD = 2'd1, OP_EV = 2'd2 } op_e;

    typedef struct packed {
        op_e         op;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [31:0] exp_rd;
        logic        exp_fn;
        logic        exp_err;
    } vec_t;

    localparam int NVEC = 34;
    localparam vec_t VECS [NVEC] = '{
        '{OP_RD, 8'h00, 32'h0,        32'h0,        1'b0, 1'b0},  // R1
        '{OP_RD, 8'h14, 32'h0,        32'h0,        1'b0, 1'b0},  // R1
        '{OP_WR, 8'h00, 32'hFFFFFFFF, 32'h0,        1'b0, 1'b0},
        '{OP_RD, 8'h00, 32'h0,        32'hFFFFFFFF, 1'b0, 1'b0},  // R9
        '{OP_WR, 8'h08, 32'hFFFFFFFF, 32'h0,        1'b0, 1'b0},
        '{OP_RD, 8'h08, 32'h0,        32'h00FFFFFF, 1'b0, 1'b0},  // R5
        '{OP_WR, 8'h10, 32'hFFFFFFFF, 32'h0,        1'b0, 1'b0},
        '{OP_RD, 8'h10, 32'h0,        32'h0001FFFF, 1'b0, 1'b0},  // R5
        '{OP_EV, 8'h00, 32'd5,        32'h0,        1'b1, 1'b0},  // R2 R6
        '{OP_RD, 8'h14, 32'h0,        32'h00000020, 1'b1, 1'b0},
        '{OP_EV, 8'h00, 32'd96,       32'h0,        1'b1, 1'b0},  // R10, masked
        '{OP_RD, 8'h20, 32'h0,        32'h00000001, 1'b1, 1'b0},  // R2 R10
        '{OP_WR, 8'h20, 32'h0,        32'h0,        1'b1, 1'b0},  // R3 zero write
        '{OP_RD, 8'h20, 32'h0,        32'h00000001, 1'b1, 1'b0},
        '{OP_WR, 8'h0C, 32'h00000001, 32'h0,        1'b1, 1'b1},  // R7 unmask
        '{OP_EV, 8'h00, 32'd40,       32'h0,        1'b1, 1'b1},
        '{OP_RD, 8'h18, 32'h0,        32'h00000100, 1'b1, 1'b1},
        '{OP_WR, 8'h14, 32'h00000020, 32'h0,        1'b0, 1'b1},  // R3 R8
        '{OP_RD, 8'h14, 32'h0,        32'h0,        1'b0, 1'b1},
        '{OP_WR, 8'h04, 32'h00000100, 32'h0,        1'b1, 1'b1},  // R8 unmask
        '{OP_WR, 8'h04, 32'h0,        32'h0,        1'b0, 1'b1},  // R8 mask
        '{OP_RD, 8'h18, 32'h0,        32'h00000100, 1'b0, 1'b1},
        '{OP_WR, 8'h18, 32'hFFFFFFFF, 32'h0,        1'b0, 1'b1},
        '{OP_RD, 8'h18, 32'h0,        32'h0,        1'b0, 1'b1},
        '{OP_EV, 8'h00, 32'd88,       32'h0,        1'b0, 1'b1},  // R5 unpopulated
        '{OP_RD, 8'h1C, 32'h0,        32'h0,        1'b0, 1'b1},
        '{OP_EV, 8'h00, 32'd130,      32'h0,        1'b0, 1'b1},  // R10
        '{OP_RD, 8'h24, 32'h0,        32'h00000004, 1'b0, 1'b1},
        '{OP_WR, 8'h20, 32'h00000001, 32'h0,        1'b0, 1'b1},  // R8 still pending
        '{OP_RD, 8'h20, 32'h0,        32'h0,        1'b0, 1'b1},
        '{OP_WR, 8'h24, 32'h00000004, 32'h0,        1'b0, 1'b0},  // R7
        '{OP_WR, 8'h28, 32'hFFFFFFFF, 32'h0,        1'b0, 1'b0},  // R9 unmapped
        '{OP_RD, 8'h28, 32'h0,        32'h0,        1'b0, 1'b0},  // R9
        '{OP_RD, 8'h00, 32'h0,        32'hFFFFFFFF, 1'b0, 1'b0}   // R9 unchanged
    };

    logic            clk;
    logic            rst_n;
    logic [NSRC-1:0] evt_in;
    logic            bus_wr;
    logic [7:0]      bus_addr;
    logic [31:0]     bus_wdata;
    logic [31:0]     bus_rdata;
    logic            irq_fn;
    logic            irq_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    evt_irq_ctrl u_evt_irq_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_in    (evt_in),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_fn    (irq_fn),
        .irq_err   (irq_err)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
        #2;
    endtask

    task automatic do_rd(input logic [7:0] a);
        @(negedge clk);
        bus_addr = a;
        #2;
    endtask

    task automatic do_ev(input int src);
        @(negedge clk);
        evt_in[src] = 1'b1;
        @(negedge clk);
        evt_in[src] = 1'b0;
        #2;
    endtask

    initial begin
        rst_n = 1'b0; evt_in = '0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #2;
        check("R1 irq_fn after reset", 32'(irq_fn), 32'd0);
        check("R1 irq_err after reset", 32'(irq_err), 32'd0);

        for (int v = 0; v < NVEC; v++) begin
            unique case (VECS[v].op)
                OP_WR: do_wr(VECS[v].addr, VECS[v].data);
                OP_RD: begin
                    do_rd(VECS[v].addr);
                    check($sformatf("R9 vector %0d rdata", v), bus_rdata, VECS[v].exp_rd);
                end
                default: do_ev(int'(VECS[v].data));
            endcase
            check($sformatf("R6 vector %0d irq_fn", v), 32'(irq_fn), 32'(VECS[v].exp_fn));
            check($sformatf("R7 vector %0d irq_err", v), 32'(irq_err), 32'(VECS[v].exp_err));
        end

        // R4: edge on source 0 and a clear of bit 0 in the same cycle.
        @(negedge clk);
        evt_in[0] = 1'b1; bus_wr = 1'b1; bus_addr = 8'h14; bus_wdata = 32'h1;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
        #2;
        check("R4 set wins over clear", bus_rdata, 32'h1);
        check("R4 irq_fn", 32'(irq_fn), 32'd1);

        // R2: line still held high; clearing must stick (no new edge).
        do_wr(8'h14, 32'h1);
        do_rd(8'h14);
        check("R2 held level no re-set", bus_rdata, 32'h0);
        check("R2 irq_fn after clear", 32'(irq_fn), 32'd0);
        @(negedge clk);
        evt_in[0] = 1'b0;

        // R1: reset in the middle of activity.
        do_ev(3);
        check("R1 pre-reset irq_fn", 32'(irq_fn), 32'd1);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #2;
        check("R1 irq_fn after mid reset", 32'(irq_fn), 32'd0);
        do_rd(8'h00);
        check("R1 enable cleared", bus_rdata, 32'h0);
        do_rd(8'h14);
        check("R1 pending cleared", bus_rdata, 32'h0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule